// File: doc/BRIEF.md
# Synchronous Rectifier Gate Timer

This block drives the two complementary synchronous-rectifier gates of a resonant converter's secondary bridge. An internal up-down timebase splits each switching period into two half-periods: the up-count from zero to the programmed period, and the down-count back to zero. Each gate belongs to one half. The gate turns on when its half begins and is held on for a programmable blanking interval, during which the current-near-zero comparator is ignored. After blanking, a rising edge of the comparator trip ends conduction early. If no trip arrives, a backstop turns the gate off a programmable dead time before the half-period ends.

Soft-start is handled by deasserting the enable. Both gates then stay off and the bridge rectifies through its body or third-quadrant conduction. A direction select swaps which half-period feeds which gate. Any change of that select restarts the timebase and clears the channel state, so the controller comes up fresh for the new power-flow direction. Per gate, a status flag records whether the last turn-off came from a trip (1) or from the backstop (0).

Top module: `srg_gate_ctrl`

## Requirements
- R1: The timebase restarts at zero on the first clock edge after reset is released and after each restart. With `dir_rev`=0, `gate_hi` turns on at the edge where the count is zero and `gate_lo` at the edge where it equals `period`. With `dir_rev`=1 these are reversed. The full switching period is 2×`period` cycles.
- R2: After a turn-on, a trip edge is ignored when it falls within the following `blank_len` edges. The first edge at which a trip can end conduction is turn-on edge + `blank_len` + 1.
- R3: `trip_in` passes through two synchronizer flops and is acted on only at a rising edge. If `trip_in` is first seen high at edge e, the active gate turns off at edge e+2 and the other gate is unaffected. A trip while no gate conducts has no effect.
- R4: Without a trip, the active gate turns off at the edge that lies D cycles before the end of its half-period, where D = `dead_len`, or 1 when `dead_len` is 0.
- R5: `gate_hi` and `gate_lo` are never high in the same cycle, and a falling gate is never followed in the same cycle by the other gate being high.
- R6: While `sr_en` is 0, both gates turn off at the next edge and stay off. When `sr_en` returns, a gate turns on only at its next turn-on point. A turn-off forced by `sr_en` leaves the status flags unchanged.
- R7: A change of `dir_rev` turns both gates off and clears both flags at the edge where it is first seen. The timebase restarts at zero on the edge after that.
- R8: `hi_trip_end` and `lo_trip_end` are set to 1 when their gate's last turn-off came from a trip and to 0 when it came from the backstop. Each holds its value until its gate's next turn-off.
- R9: While `rst` is high, both gates and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period | input | CNT_W | Half-period length in clock cycles (timebase peak) |
| blank_len | input | BLANK_W | Blanking length in cycles after each turn-on |
| dead_len | input | DEAD_W | Dead time before each half-period end (0 acts as 1) |
| sr_en | input | 1 | Enables rectifier gating; low during soft-start |
| trip_in | input | 1 | Asynchronous current-near-zero comparator trip |
| dir_rev | input | 1 | Power-flow direction: 0 forward, 1 reverse |
| gate_hi | output | 1 | High-side rectifier gate |
| gate_lo | output | 1 | Low-side rectifier gate |
| hi_trip_end | output | 1 | 1 if the high gate's last turn-off was by trip |
| lo_trip_end | output | 1 | 1 if the low gate's last turn-off was by trip |

## Verification
Gates change at the same edge that samples their timebase event or their enable, so every check is taken at the falling clock edge after the edge in question. A trip first seen at edge e is due two edges later, and the bench places its expected turn-off there, with blanking and backstop windows worked out from `period`, `blank_len` and the effective dead time. A direction change takes effect at the edge that sees it, and the new frame starts one edge later. The bench therefore samples the cleared state right after the change and restarts its step count for the new frame.

// File: rtl/srg_pkg.sv
package srg_pkg;

    // Half-period indices: the up-count half and the down-count half
    localparam int NUM_HALF = 2;
    localparam int HALF_UP  = 0;
    localparam int HALF_DN  = 1;

    // Timebase events, one bit per half-period
    typedef struct packed {
        logic [NUM_HALF-1:0] start;   // turn-on point of the half
        logic [NUM_HALF-1:0] stop;    // backstop point of the half
    } tb_event_t;

    // Conduction state of one rectifier channel
    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_BLANK = 2'd1,
        CH_ARMED = 2'd2
    } chan_state_e;

    function automatic logic chan_conducts(chan_state_e s);
        return (s == CH_BLANK) || (s == CH_ARMED);
    endfunction

endpackage

// File: rtl/srg_trip_edge.sv
module srg_trip_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trip_in,
    output logic trip_rise
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q[0] <= 1'b0;
        end else begin
            sync_q[0] <= trip_in;
        end
    end

    // Remaining synchronizer stages
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q[i] <= 1'b0;
            end else begin
                sync_q[i] <= sync_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= 1'b0;
        end else begin
            last_q <= sync_q[STAGES-1];
        end
    end

    // One-cycle pulse on a synchronized rising edge
    assign trip_rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/srg_timebase.sv
module srg_timebase
    import srg_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int DEAD_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [CNT_W-1:0]  period,
    input  logic [DEAD_W-1:0] dead_len,
    output tb_event_t         ev
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0]    cnt_q;
    logic                up_q;
    logic [CNT_W-1:0]    dead_eff;
    logic [NUM_HALF-1:0] start_v;
    logic [NUM_HALF-1:0] stop_v;

    // A dead time of zero would let the next gate start in the same
    // cycle the previous one stops; one cycle is the floor.
    always_comb begin
        dead_eff = (dead_len == '0) ? CNT_ONE : CNT_W'(dead_len);
    end

    // Up-down count: 0 .. period .. 1, 0 ...
    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (up_q) begin
            if (cnt_q == period) begin
                up_q  <= 1'b0;
                cnt_q <= cnt_q - CNT_ONE;
            end else begin
                cnt_q <= cnt_q + CNT_ONE;
            end
        end else begin
            if (cnt_q == '0) begin
                up_q  <= 1'b1;
                cnt_q <= cnt_q + CNT_ONE;
            end else begin
                cnt_q <= cnt_q - CNT_ONE;
            end
        end
    end

    for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
        if (h == HALF_UP) begin : g_up
            assign start_v[h] = (cnt_q == '0);
            assign stop_v[h]  = up_q && (cnt_q == (period - dead_eff));
        end else begin : g_dn
            assign start_v[h] = (cnt_q == period);
            assign stop_v[h]  = !up_q && (cnt_q == dead_eff);
        end
    end

    assign ev = '{start: start_v, stop: stop_v};

endmodule

// File: rtl/srg_gate_chan.sv
module srg_gate_chan
    import srg_pkg::*;
#(
    parameter int BLANK_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic               enable,
    input  logic               start,
    input  logic               stop,
    input  logic               trip_rise,
    input  logic [BLANK_W-1:0] blank_len,
    output logic               gate,
    output logic               ended_by_trip
);

    localparam logic [BLANK_W-1:0] BLK_ONE = BLANK_W'(1);

    chan_state_e        st_q;
    logic [BLANK_W-1:0] bcnt_q;
    logic               by_trip_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            st_q      <= CH_OFF;
            bcnt_q    <= '0;
            by_trip_q <= 1'b0;
        end else if (!enable) begin
            // Soft-start: drop conduction, keep the last turn-off cause
            st_q   <= CH_OFF;
            bcnt_q <= '0;
        end else begin
            unique case (st_q)
                CH_OFF: begin
                    if (start) begin
                        bcnt_q <= blank_len;
                        st_q   <= (blank_len == '0) ? CH_ARMED : CH_BLANK;
                    end
                end
                CH_BLANK: begin
                    if (stop) begin
                        st_q      <= CH_OFF;
                        bcnt_q    <= '0;
                        by_trip_q <= 1'b0;
                    end else if (bcnt_q <= BLK_ONE) begin
                        st_q   <= CH_ARMED;
                        bcnt_q <= '0;
                    end else begin
                        bcnt_q <= bcnt_q - BLK_ONE;
                    end
                end
                CH_ARMED: begin
                    // Backstop has priority over a coincident trip
                    if (stop) begin
                        st_q      <= CH_OFF;
                        by_trip_q <= 1'b0;
                    end else if (trip_rise) begin
                        st_q      <= CH_OFF;
                        by_trip_q <= 1'b1;
                    end
                end
                default: begin
                    st_q   <= CH_OFF;
                    bcnt_q <= '0;
                end
            endcase
        end
    end

    assign gate          = chan_conducts(st_q);
    assign ended_by_trip = by_trip_q;

endmodule

// File: rtl/srg_gate_ctrl.sv
module srg_gate_ctrl
    import srg_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int BLANK_W   = 8,
    parameter int DEAD_W    = 6,
    parameter int TRIP_SYNC = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   period,
    input  logic [BLANK_W-1:0] blank_len,
    input  logic [DEAD_W-1:0]  dead_len,
    input  logic               sr_en,
    input  logic               trip_in,
    input  logic               dir_rev,
    output logic               gate_hi,
    output logic               gate_lo,
    output logic               hi_trip_end,
    output logic               lo_trip_end
);

    logic                dir_q;
    logic                restart;
    logic                trip_rise;
    tb_event_t           ev;
    logic [NUM_HALF-1:0] ch_gate;
    logic [NUM_HALF-1:0] ch_trip;

    // Direction register; it follows dir_rev in reset too, so leaving
    // reset never counts as a direction change.
    always_ff @(posedge clk) begin
        dir_q <= dir_rev;
    end

    assign restart = (dir_rev != dir_q);

    srg_trip_edge #(
        .STAGES (TRIP_SYNC)
    ) u_trip (
        .clk       (clk),
        .rst       (rst),
        .trip_in   (trip_in),
        .trip_rise (trip_rise)
    );

    srg_timebase #(
        .CNT_W  (CNT_W),
        .DEAD_W (DEAD_W)
    ) u_tb (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .period   (period),
        .dead_len (dead_len),
        .ev       (ev)
    );

    for (genvar h = 0; h < NUM_HALF; h++) begin : g_chan
        srg_gate_chan #(
            .BLANK_W (BLANK_W)
        ) u_chan (
            .clk           (clk),
            .rst           (rst),
            .restart       (restart),
            .enable        (sr_en),
            .start         (ev.start[h]),
            .stop          (ev.stop[h]),
            .trip_rise     (trip_rise),
            .blank_len     (blank_len),
            .gate          (ch_gate[h]),
            .ended_by_trip (ch_trip[h])
        );
    end

    // Reverse flow exchanges which half-period feeds which gate
    always_comb begin
        if (dir_q) begin
            gate_hi     = ch_gate[HALF_DN];
            gate_lo     = ch_gate[HALF_UP];
            hi_trip_end = ch_trip[HALF_DN];
            lo_trip_end = ch_trip[HALF_UP];
        end else begin
            gate_hi     = ch_gate[HALF_UP];
            gate_lo     = ch_gate[HALF_DN];
            hi_trip_end = ch_trip[HALF_UP];
            lo_trip_end = ch_trip[HALF_DN];
        end
    end

endmodule

// File: rtl/srg_gate_ctrl_chk.sv
module srg_gate_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic sr_en,
    input logic dir_rev,
    input logic dir_q,
    input logic gate_hi,
    input logic gate_lo,
    input logic hi_trip_end,
    input logic lo_trip_end
);

    // R9: reset forces both gates off
    p_reset_off_r9: assert property (@(posedge clk)
        rst |=> (!gate_hi && !gate_lo));

    // R5: gates never overlap
    p_interlock_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({gate_hi, gate_lo}));

    // R4 / R5: a falling gate is not followed at once by the other gate
    p_dead_hi_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(gate_hi) |-> !gate_lo);

    p_dead_lo_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(gate_lo) |-> !gate_hi);

    // R6: disabled rectification shuts both gates at the next edge
    p_softstart_off_r6: assert property (@(posedge clk) disable iff (rst)
        !sr_en |=> (!gate_hi && !gate_lo));

    // R7: a direction change clears gates and flags
    p_dir_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (dir_rev != dir_q) |=> (!gate_hi && !gate_lo && !hi_trip_end && !lo_trip_end));

    // R8: a flag only moves when its gate falls or on a direction change
    p_flag_hold_hi_r8: assert property (@(posedge clk) disable iff (rst)
        (!$fell(gate_hi) && $past(dir_rev == dir_q)) |-> $stable(hi_trip_end));

    p_flag_hold_lo_r8: assert property (@(posedge clk) disable iff (rst)
        (!$fell(gate_lo) && $past(dir_rev == dir_q)) |-> $stable(lo_trip_end));

endmodule

bind srg_gate_ctrl srg_gate_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .sr_en       (sr_en),
    .dir_rev     (dir_rev),
    .dir_q       (dir_q),
    .gate_hi     (gate_hi),
    .gate_lo     (gate_lo),
    .hi_trip_end (hi_trip_end),
    .lo_trip_end (lo_trip_end)
);

// File: tb/tb_srg_gate_ctrl.sv
module tb_srg_gate_ctrl;

    localparam int CNT_W   = 12;
    localparam int BLANK_W = 8;
    localparam int DEAD_W  = 6;
    localparam int P       = 12;
    localparam int B       = 3;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [CNT_W-1:0]   period = CNT_W'(P);
    logic [BLANK_W-1:0] blank_len = BLANK_W'(B);
    logic [DEAD_W-1:0]  dead_len = DEAD_W'(2);
    logic               sr_en = 1'b1;
    logic               trip_in = 1'b0;
    logic               dir_rev = 1'b0;
    logic               gate_hi, gate_lo, hi_trip_end, lo_trip_end;

    int  checks = 0;
    int  errors = 0;
    int  deff = 2;
    bit  rev = 1'b0;
    bit  fl [2] = '{1'b0, 1'b0};

    always #10 clk = ~clk;

    srg_gate_ctrl #(
        .CNT_W   (CNT_W),
        .BLANK_W (BLANK_W),
        .DEAD_W  (DEAD_W)
    ) dut (
        .clk         (clk),
        .rst         (rst),
        .period      (period),
        .blank_len   (blank_len),
        .dead_len    (dead_len),
        .sr_en       (sr_en),
        .trip_in     (trip_in),
        .dir_rev     (dir_rev),
        .gate_hi     (gate_hi),
        .gate_lo     (gate_lo),
        .hi_trip_end (hi_trip_end),
        .lo_trip_end (lo_trip_end)
    );

    task automatic chk(input string tag, input logic act, input logic exp, input int step);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s step %0d: actual %0b expected %0b", tag, step, act, exp);
        end
    endtask

    function automatic bit en_ok(input int lo, input int hi, input int off_lo, input int off_hi);
        return (hi < off_lo) || (lo >= off_hi);
    endfunction

    // One frame of `len` edges starting at timebase zero.
    // trip_e < 0: no trip; otherwise trip_in is first seen at edge trip_e.
    // sr_en is low at edges off_lo .. off_hi-1.
    task automatic run_frame(input int len, input int trip_e, input int off_lo, input int off_hi);
        int  a;
        int  s    [2];
        int  endm [2];
        bit  tok  [2];
        bit  g    [2];
        string tg [2];
        a = trip_e + 2;
        for (int h = 0; h < 2; h++) begin
            s[h]    = h * P;
            tok[h]  = (trip_e >= 0) && (a >= s[h] + B + 1) && (a < s[h] + P - deff);
            endm[h] = tok[h] ? a : s[h] + P - deff;
            if (rev)                                   tg[h] = "R7 reverse gate";
            else if (off_hi > off_lo)                  tg[h] = "R6 soft-start gate";
            else if (tok[h])                           tg[h] = "R3 trip turn-off";
            else if (trip_e >= 0 && a >= s[h] && a <= s[h] + B) tg[h] = "R2 blanking";
            else                                       tg[h] = "R1 R4 turn-on/backstop";
        end
        for (int m = 0; m < len; m++) begin
            sr_en   = !(m >= off_lo && m < off_hi);
            trip_in = (trip_e >= 0) && (m == trip_e || m == trip_e + 1);
            @(posedge clk);
            @(negedge clk);
            for (int h = 0; h < 2; h++) begin
                g[h] = (m >= s[h]) && (m < endm[h]) && en_ok(s[h], m, off_lo, off_hi);
                if (m == endm[h] && en_ok(s[h], endm[h], off_lo, off_hi))
                    fl[h] = tok[h];
            end
            chk(rev ? tg[1] : tg[0], gate_hi, rev ? g[1] : g[0], m);
            chk(rev ? tg[0] : tg[1], gate_lo, rev ? g[0] : g[1], m);
            chk("R8 high flag", hi_trip_end, rev ? fl[1] : fl[0], m);
            chk("R8 low flag",  lo_trip_end, rev ? fl[0] : fl[1], m);
            chk("R5 interlock", gate_hi & gate_lo, 1'b0, m);
        end
        trip_in = 1'b0;
        sr_en   = 1'b1;
    endtask

    // Direction change; the frame restarts on the edge after this one
    task automatic swap_dir(input bit nd, input int nd_dead);
        dir_rev  = nd;
        dead_len = DEAD_W'(nd_dead);
        deff     = (nd_dead == 0) ? 1 : nd_dead;
        rev      = nd;
        @(posedge clk);
        @(negedge clk);
        fl[0] = 1'b0;
        fl[1] = 1'b0;
        chk("R7 reinit high gate", gate_hi, 1'b0, 0);
        chk("R7 reinit low gate",  gate_lo, 1'b0, 0);
        chk("R7 reinit high flag", hi_trip_end, 1'b0, 0);
        chk("R7 reinit low flag",  lo_trip_end, 1'b0, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk("R9 reset high gate", gate_hi, 1'b0, 0);
        chk("R9 reset low gate",  gate_lo, 1'b0, 0);
        chk("R9 reset high flag", hi_trip_end, 1'b0, 0);
        chk("R9 reset low flag",  lo_trip_end, 1'b0, 0);
        rst = 1'b0;

        // R1 R4: plain frame, backstop on both halves
        run_frame(2 * P, -1, 0, 0);
        // R2 R3 R8: trip swept over every placement in the frame
        for (int e = 0; e <= 2 * P - 3; e++) run_frame(2 * P, e, 0, 0);
        run_frame(2 * P, -1, 0, 0);

        // R6: disable mid-conduction, re-enable after the low gate's start
        run_frame(2 * P, -1, 4, P + 2);
        run_frame(2 * P, 5, 0, 0);
        // R6: whole frame disabled with a trip present
        run_frame(2 * P, 6, 0, 2 * P);
        // R6: disable late in the second half after a trip there
        run_frame(2 * P, P + 4, P + 8, 2 * P);
        run_frame(2 * P, -1, 0, 0);

        // R7: reverse direction with dead time 0 (acts as 1)
        swap_dir(1'b1, 0);
        for (int e = 0; e <= 2 * P - 3; e += 3) run_frame(2 * P, e, 0, 0);
        run_frame(2 * P, -1, 0, 0);

        // R7: swap back in the middle of a conduction interval
        run_frame(7, 5, 0, 0);
        swap_dir(1'b0, 3);
        run_frame(2 * P, P + 6, 0, 0);
        run_frame(2 * P, 4, 0, 0);
        run_frame(2 * P, -1, 0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule